// File: doc/BRIEF.md
# Dual External Bus Access Sequencer

The block sequences single accesses from an internal requester onto one of two physical external buses: a primary bus and a calibration bus. Each request carries a 24-bit address, a write flag, a 2-bit transfer size and a 32-bit write word. The address is compared against a parameterised table of chip-select regions. Each region is tagged as belonging to either the primary bus or the calibration bus, and that tag selects the bus that carries the access. An address that hits no region runs on the primary bus with no chip select asserted.

Only one access is ever in flight, so the two buses are never active together. An access opens with a one-clock transfer-start pulse. Its chip select, and its output enable for reads, stay up until the transfer acknowledge of the selected bus is sampled high; read data is taken on that same edge. The controller can take the next request in the acknowledge cycle, and it then starts it with no gap, but only when that request targets the same bus and the same chip select (or again no chip select). When the target changes, the controller leaves exactly one idle cycle on both buses before the next transfer start.

Top module: `ebus_steer`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, every output of both buses is low, rsp_valid_o is low and req_ready_o is high.
- R2: With the default table, address bits [23:20] pick the target. A value of 0 selects the primary bus with chip-select bit 0, and 1 selects the primary bus with bit 1. A value of 2 selects the calibration bus with chip-select bit 2, and 3 selects the calibration bus with bit 3. Any other value selects the primary bus with no chip-select bit set. At most one chip-select bit is high across both buses, and the lowest-numbered matching region wins.
- R3: The two buses never carry an access at the same time. The bus that is not carrying the access drives address, transfer start, read/write, size, output enable, chip select and write data all low.
- R4: The selected bus raises transfer start for exactly the one cycle that follows request acceptance. From that same cycle it presents the address, the read/write line (1 = read), the unchanged size code and, for writes only, the write word.
- R5: The chip select, and for reads the output enable, stay unchanged from the transfer-start cycle up to and including the cycle in which the selected bus's acknowledge is sampled high. Writes never raise the output enable.
- R6: rsp_valid_o is high for one cycle, in the cycle that follows the acknowledge edge. In that cycle rsp_rdata_o holds the selected bus's read data for a read, and zero for a write.
- R7: In the acknowledge cycle, req_ready_o is high when the waiting request targets the same bus and the same chip select as the finishing access, or no chip select again. That request's transfer start then follows in the very next cycle.
- R8: When the waiting request targets a different bus or chip select, req_ready_o is low in the acknowledge cycle. The next cycle shows no transfer start and no chip select on either bus, with req_ready_o high. The transfer start follows one cycle after that.
- R9: Both burst-in-progress outputs are always low.
- R10: The acknowledge and read data of the bus not carrying the access have no effect on the access in flight.
- R11: req_ready_o is low while an access waits for its acknowledge, and high whenever no access is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request taken on this edge when valid |
| req_addr_i | input | 24 | Request address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Transfer size code |
| req_wdata_i | input | 32 | Write word |
| rsp_valid_o | output | 1 | Access completed |
| rsp_rdata_o | output | 32 | Read word of the completed access |
| pri_addr_o | output | 24 | Primary bus address |
| pri_ts_o | output | 1 | Primary transfer start |
| pri_rw_o | output | 1 | Primary read/write, 1 = read |
| pri_size_o | output | 2 | Primary transfer size |
| pri_burst_o | output | 1 | Primary burst in progress, always low |
| pri_oe_o | output | 1 | Primary output enable |
| pri_cs_o | output | 4 | Primary chip selects, one bit per region |
| pri_wdata_o | output | 32 | Primary write data |
| pri_ta_i | input | 1 | Primary transfer acknowledge |
| pri_rdata_i | input | 32 | Primary read data |
| cal_addr_o | output | 24 | Calibration bus address |
| cal_ts_o | output | 1 | Calibration transfer start |
| cal_rw_o | output | 1 | Calibration read/write, 1 = read |
| cal_size_o | output | 2 | Calibration transfer size |
| cal_burst_o | output | 1 | Calibration burst in progress, always low |
| cal_oe_o | output | 1 | Calibration output enable |
| cal_cs_o | output | 4 | Calibration chip selects, one bit per region |
| cal_wdata_o | output | 32 | Calibration write data |
| cal_ta_i | input | 1 | Calibration transfer acknowledge |
| cal_rdata_i | input | 32 | Calibration read data |

## Verification
The hardest case to reach is a request that is already waiting at the moment the acknowledge arrives. Only then does the choice between a zero-gap start and a one-cycle dead gap become visible. The bench therefore presents the next request in the same cycle that it raises the selected acknowledge. It does this in directed pairs that cover calibration to primary, a change of primary chip select, same-select pairs and unmatched-to-unmatched pairs. A seeded random run then chains about half of its accesses, with random wait lengths. In every cycle the bench also toggles the acknowledge of the idle bus at random, so that any leak across the two buses shows up.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  localparam int unsigned REG_IDX_W = 4;
  localparam int unsigned N_BUS = 2;
  localparam int unsigned BUS_PRI = 0;
  localparam int unsigned BUS_CAL = 1;

  typedef struct packed {
    logic                 cal;
    logic                 hit;
    logic [REG_IDX_W-1:0] idx;
  } sel_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/ebus_region_dec.sv
module ebus_region_dec
  import ebus_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned N_REG = 4,
  parameter logic [N_REG*ADDR_W-1:0] REG_BASE = '0,
  parameter logic [N_REG*ADDR_W-1:0] REG_MASK = '0,
  parameter logic [N_REG-1:0] REG_CAL = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_t              sel_o
);
  logic [N_REG-1:0] hit;

  for (genvar g = 0; g < N_REG; g++) begin : g_cmp
    localparam logic [ADDR_W-1:0] BASE = REG_BASE[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] MASK = REG_MASK[g*ADDR_W +: ADDR_W];
    assign hit[g] = (((addr_i ^ BASE) & MASK) == '0);
  end

  // lowest index wins: scan downwards, last hit overrides
  always_comb begin
    sel_o = '0;
    for (int i = int'(N_REG) - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_o.hit = 1'b1;
        sel_o.cal = REG_CAL[i];
        sel_o.idx = REG_IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [1:0]        req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  sel_t              req_sel_i,
  input  logic              ta_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              busy_o,
  output logic              ts_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              cur_we_o,
  output logic [1:0]        cur_size_o,
  output logic [DATA_W-1:0] cur_wdata_o,
  output sel_t              cur_sel_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  seq_state_e state_q;
  logic       done;
  logic       same_target;
  logic       accept;

  assign busy_o      = (state_q == ST_BUSY);
  assign done        = busy_o && ta_i;
  assign same_target = (req_sel_i == cur_sel_o);
  // idle state doubles as the dead cycle; only a same-target request chains
  assign req_ready_o = !busy_o || (done && same_target);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ts_o        <= 1'b0;
      cur_addr_o  <= '0;
      cur_we_o    <= 1'b0;
      cur_size_o  <= '0;
      cur_wdata_o <= '0;
      cur_sel_o   <= '0;
    end else if (accept) begin
      state_q     <= ST_BUSY;
      ts_o        <= 1'b1;
      cur_addr_o  <= req_addr_i;
      cur_we_o    <= req_we_i;
      cur_size_o  <= req_size_i;
      cur_wdata_o <= req_wdata_i;
      cur_sel_o   <= req_sel_i;
    end else begin
      ts_o <= 1'b0;
      if (done) state_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= done;
      if (done) rsp_rdata_o <= cur_we_o ? '0 : rdata_i;
    end
  end
endmodule

// File: rtl/ebus_port_mux.sv
module ebus_port_mux
  import ebus_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_REG = 4
) (
  input  logic                          busy_i,
  input  logic                          ts_i,
  input  logic [ADDR_W-1:0]             cur_addr_i,
  input  logic                          cur_we_i,
  input  logic [1:0]                    cur_size_i,
  input  logic [DATA_W-1:0]             cur_wdata_i,
  input  sel_t                          cur_sel_i,
  input  logic [N_BUS-1:0]              bus_ta_i,
  input  logic [N_BUS-1:0][DATA_W-1:0]  bus_rdata_i,
  output logic [N_BUS-1:0][ADDR_W-1:0]  bus_addr_o,
  output logic [N_BUS-1:0]              bus_ts_o,
  output logic [N_BUS-1:0]              bus_rw_o,
  output logic [N_BUS-1:0][1:0]         bus_size_o,
  output logic [N_BUS-1:0]              bus_burst_o,
  output logic [N_BUS-1:0]              bus_oe_o,
  output logic [N_BUS-1:0][N_REG-1:0]   bus_cs_o,
  output logic [N_BUS-1:0][DATA_W-1:0]  bus_wdata_o,
  output logic                          ta_o,
  output logic [DATA_W-1:0]             rdata_o
);
  for (genvar b = 0; b < N_BUS; b++) begin : g_bus
    localparam logic IS_CAL = (b == BUS_CAL);
    logic on;
    assign on             = busy_i && (cur_sel_i.cal == IS_CAL);
    assign bus_addr_o[b]  = on ? cur_addr_i : '0;
    assign bus_ts_o[b]    = on && ts_i;
    assign bus_rw_o[b]    = on && !cur_we_i;
    assign bus_size_o[b]  = on ? cur_size_i : 2'b00;
    assign bus_burst_o[b] = 1'b0;
    assign bus_oe_o[b]    = on && !cur_we_i;
    assign bus_wdata_o[b] = (on && cur_we_i) ? cur_wdata_i : '0;
    for (genvar r = 0; r < N_REG; r++) begin : g_cs
      assign bus_cs_o[b][r] = on && cur_sel_i.hit && (cur_sel_i.idx == REG_IDX_W'(r));
    end
  end

  assign ta_o    = cur_sel_i.cal ? bus_ta_i[BUS_CAL] : bus_ta_i[BUS_PRI];
  assign rdata_o = cur_sel_i.cal ? bus_rdata_i[BUS_CAL] : bus_rdata_i[BUS_PRI];
endmodule

// File: rtl/ebus_steer.sv
module ebus_steer
  import ebus_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_REG = 4,
  parameter logic [N_REG*ADDR_W-1:0] REG_BASE = {24'h300000, 24'h200000, 24'h100000, 24'h000000},
  parameter logic [N_REG*ADDR_W-1:0] REG_MASK = {4{24'hF00000}},
  parameter logic [N_REG-1:0] REG_CAL = 4'b1100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [1:0]        req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] pri_addr_o,
  output logic              pri_ts_o,
  output logic              pri_rw_o,
  output logic [1:0]        pri_size_o,
  output logic              pri_burst_o,
  output logic              pri_oe_o,
  output logic [N_REG-1:0]  pri_cs_o,
  output logic [DATA_W-1:0] pri_wdata_o,
  input  logic              pri_ta_i,
  input  logic [DATA_W-1:0] pri_rdata_i,
  output logic [ADDR_W-1:0] cal_addr_o,
  output logic              cal_ts_o,
  output logic              cal_rw_o,
  output logic [1:0]        cal_size_o,
  output logic              cal_burst_o,
  output logic              cal_oe_o,
  output logic [N_REG-1:0]  cal_cs_o,
  output logic [DATA_W-1:0] cal_wdata_o,
  input  logic              cal_ta_i,
  input  logic [DATA_W-1:0] cal_rdata_i
);
  sel_t              req_sel;
  sel_t              cur_sel;
  logic              busy;
  logic              ts;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_we;
  logic [1:0]        cur_size;
  logic [DATA_W-1:0] cur_wdata;
  logic              ta_sel;
  logic [DATA_W-1:0] rdata_sel;

  logic [N_BUS-1:0]             bus_ta;
  logic [N_BUS-1:0][DATA_W-1:0] bus_rdata;
  logic [N_BUS-1:0][ADDR_W-1:0] bus_addr;
  logic [N_BUS-1:0]             bus_ts;
  logic [N_BUS-1:0]             bus_rw;
  logic [N_BUS-1:0][1:0]        bus_size;
  logic [N_BUS-1:0]             bus_burst;
  logic [N_BUS-1:0]             bus_oe;
  logic [N_BUS-1:0][N_REG-1:0]  bus_cs;
  logic [N_BUS-1:0][DATA_W-1:0] bus_wdata;

  ebus_region_dec #(
    .ADDR_W(ADDR_W), .N_REG(N_REG),
    .REG_BASE(REG_BASE), .REG_MASK(REG_MASK), .REG_CAL(REG_CAL)
  ) u_dec (
    .addr_i(req_addr_i),
    .sel_o (req_sel)
  );

  ebus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .req_we_i    (req_we_i),
    .req_size_i  (req_size_i),
    .req_wdata_i (req_wdata_i),
    .req_sel_i   (req_sel),
    .ta_i        (ta_sel),
    .rdata_i     (rdata_sel),
    .busy_o      (busy),
    .ts_o        (ts),
    .cur_addr_o  (cur_addr),
    .cur_we_o    (cur_we),
    .cur_size_o  (cur_size),
    .cur_wdata_o (cur_wdata),
    .cur_sel_o   (cur_sel),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  assign bus_ta[BUS_PRI]    = pri_ta_i;
  assign bus_ta[BUS_CAL]    = cal_ta_i;
  assign bus_rdata[BUS_PRI] = pri_rdata_i;
  assign bus_rdata[BUS_CAL] = cal_rdata_i;

  ebus_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_REG(N_REG)) u_mux (
    .busy_i      (busy),
    .ts_i        (ts),
    .cur_addr_i  (cur_addr),
    .cur_we_i    (cur_we),
    .cur_size_i  (cur_size),
    .cur_wdata_i (cur_wdata),
    .cur_sel_i   (cur_sel),
    .bus_ta_i    (bus_ta),
    .bus_rdata_i (bus_rdata),
    .bus_addr_o  (bus_addr),
    .bus_ts_o    (bus_ts),
    .bus_rw_o    (bus_rw),
    .bus_size_o  (bus_size),
    .bus_burst_o (bus_burst),
    .bus_oe_o    (bus_oe),
    .bus_cs_o    (bus_cs),
    .bus_wdata_o (bus_wdata),
    .ta_o        (ta_sel),
    .rdata_o     (rdata_sel)
  );

  assign pri_addr_o  = bus_addr[BUS_PRI];
  assign pri_ts_o    = bus_ts[BUS_PRI];
  assign pri_rw_o    = bus_rw[BUS_PRI];
  assign pri_size_o  = bus_size[BUS_PRI];
  assign pri_burst_o = bus_burst[BUS_PRI];
  assign pri_oe_o    = bus_oe[BUS_PRI];
  assign pri_cs_o    = bus_cs[BUS_PRI];
  assign pri_wdata_o = bus_wdata[BUS_PRI];

  assign cal_addr_o  = bus_addr[BUS_CAL];
  assign cal_ts_o    = bus_ts[BUS_CAL];
  assign cal_rw_o    = bus_rw[BUS_CAL];
  assign cal_size_o  = bus_size[BUS_CAL];
  assign cal_burst_o = bus_burst[BUS_CAL];
  assign cal_oe_o    = bus_oe[BUS_CAL];
  assign cal_cs_o    = bus_cs[BUS_CAL];
  assign cal_wdata_o = bus_wdata[BUS_CAL];
endmodule

// File: rtl/ebus_steer_chk.sv
module ebus_steer_chk #(
  parameter int unsigned N_REG = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             pri_ts_o,
  input logic             pri_oe_o,
  input logic             pri_burst_o,
  input logic [N_REG-1:0] pri_cs_o,
  input logic             pri_ta_i,
  input logic             cal_ts_o,
  input logic             cal_oe_o,
  input logic             cal_burst_o,
  input logic [N_REG-1:0] cal_cs_o,
  input logic             cal_ta_i
);
  logic pri_on;
  logic cal_on;
  logic pri_wait;
  logic cal_wait;

  assign pri_on   = pri_ts_o || pri_oe_o || (|pri_cs_o);
  assign cal_on   = cal_ts_o || cal_oe_o || (|cal_cs_o);
  assign pri_wait = (|pri_cs_o) && !pri_ta_i;
  assign cal_wait = (|cal_cs_o) && !cal_ta_i;

  assert_bus_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pri_on && cal_on));

  assert_cs_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pri_cs_o, cal_cs_o}));

  assert_ts_follows_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (pri_ts_o || cal_ts_o));

  assert_ts_has_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_ts_o || cal_ts_o) |-> $past(req_valid_i && req_ready_o));

  assert_pri_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_wait |=> ($stable(pri_cs_o) && $stable(pri_oe_o)));

  assert_cal_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_wait |=> ($stable(cal_cs_o) && $stable(cal_oe_o)));

  assert_wait_not_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_wait || cal_wait) |-> !req_ready_o);

  assert_cal_dead_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(|cal_cs_o) && !(|cal_cs_o)) |-> !pri_ts_o);

  assert_no_burst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pri_burst_o || cal_burst_o));
endmodule

bind ebus_steer ebus_steer_chk #(.N_REG(N_REG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .pri_ts_o    (pri_ts_o),
  .pri_oe_o    (pri_oe_o),
  .pri_burst_o (pri_burst_o),
  .pri_cs_o    (pri_cs_o),
  .pri_ta_i    (pri_ta_i),
  .cal_ts_o    (cal_ts_o),
  .cal_oe_o    (cal_oe_o),
  .cal_burst_o (cal_burst_o),
  .cal_cs_o    (cal_cs_o),
  .cal_ta_i    (cal_ta_i)
);

// File: tb/sim_ebus_steer.sv
`timescale 1ns/1ps
module sim_ebus_steer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [23:0] req_addr_i = '0;
  logic        req_we_i = 1'b0;
  logic [1:0]  req_size_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic [23:0] pri_addr_o, cal_addr_o;
  logic        pri_ts_o, pri_rw_o, pri_burst_o, pri_oe_o;
  logic        cal_ts_o, cal_rw_o, cal_burst_o, cal_oe_o;
  logic [1:0]  pri_size_o, cal_size_o;
  logic [3:0]  pri_cs_o, cal_cs_o;
  logic [31:0] pri_wdata_o, cal_wdata_o;
  logic        pri_ta_i = 1'b0, cal_ta_i = 1'b0;
  logic [31:0] pri_rdata_i = '0, cal_rdata_i = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  ebus_steer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_we_i(req_we_i), .req_size_i(req_size_i),
    .req_wdata_i(req_wdata_i), .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .pri_addr_o(pri_addr_o), .pri_ts_o(pri_ts_o), .pri_rw_o(pri_rw_o),
    .pri_size_o(pri_size_o), .pri_burst_o(pri_burst_o), .pri_oe_o(pri_oe_o),
    .pri_cs_o(pri_cs_o), .pri_wdata_o(pri_wdata_o), .pri_ta_i(pri_ta_i),
    .pri_rdata_i(pri_rdata_i),
    .cal_addr_o(cal_addr_o), .cal_ts_o(cal_ts_o), .cal_rw_o(cal_rw_o),
    .cal_size_o(cal_size_o), .cal_burst_o(cal_burst_o), .cal_oe_o(cal_oe_o),
    .cal_cs_o(cal_cs_o), .cal_wdata_o(cal_wdata_o), .cal_ta_i(cal_ta_i),
    .cal_rdata_i(cal_rdata_i)
  );

  logic [64:0] pri_vec, cal_vec;
  assign pri_vec = {pri_addr_o, pri_ts_o, pri_rw_o, pri_size_o, pri_oe_o, pri_cs_o, pri_wdata_o};
  assign cal_vec = {cal_addr_o, cal_ts_o, cal_rw_o, cal_size_o, cal_oe_o, cal_cs_o, cal_wdata_o};

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {cal, hit, idx[3:0]} per the default region table
  function automatic logic [5:0] id_of(input logic [23:0] a);
    case (a[23:20])
      4'd0: return {1'b0, 1'b1, 4'd0};
      4'd1: return {1'b0, 1'b1, 4'd1};
      4'd2: return {1'b1, 1'b1, 4'd2};
      4'd3: return {1'b1, 1'b1, 4'd3};
      default: return 6'b0;
    endcase
  endfunction

  function automatic logic [64:0] bus_vec(input logic [23:0] a, input logic we, input logic [1:0] sz,
                                          input logic [31:0] wd, input logic ts, input logic side);
    logic [5:0] id;
    logic [3:0] cs;
    id = id_of(a);
    if (id[5] != side) return '0;
    cs = id[4] ? (4'b0001 << id[3:0]) : 4'b0000;
    return {a, ts, ~we, sz, ~we, cs, (we ? wd : 32'h0)};
  endfunction

  task automatic drive_req(input logic [23:0] a, input logic we, input logic [1:0] sz, input logic [31:0] wd);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    req_we_i    = we;
    req_size_i  = sz;
    req_wdata_i = wd;
  endtask

  // from idle: present request, expect acceptance, return at negedge of the transfer-start cycle
  task automatic launch(input logic [23:0] a, input logic we, input logic [1:0] sz, input logic [31:0] wd);
    drive_req(a, we, sz, wd);
    #1;
    chk(req_ready_o == 1'b1, "R11 ready while idle", 80'(req_ready_o), 80'(1));
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  // entered at negedge of the transfer-start cycle
  task automatic serve(input logic [23:0] a, input logic we, input logic [1:0] sz, input logic [31:0] wd,
                       input int waits, input bit chain,
                       input logic [23:0] na, input logic nwe, input logic [1:0] nsz, input logic [31:0] nwd);
    logic       c;
    logic       same;
    logic [31:0] rd;
    c    = id_of(a)[5];
    same = (id_of(a) == id_of(na));
    rd   = '0;
    for (int i = 0; i <= waits; i++) begin
      pri_ta_i = 1'b0;
      cal_ta_i = 1'b0;
      // idle bus acknowledge toggles at random (R10)
      if (c) begin pri_ta_i = 1'($urandom % 2); pri_rdata_i = $urandom; end
      else begin cal_ta_i = 1'($urandom % 2); cal_rdata_i = $urandom; end
      if (i == waits) begin
        rd = $urandom;
        if (c) begin cal_ta_i = 1'b1; cal_rdata_i = rd; end
        else begin pri_ta_i = 1'b1; pri_rdata_i = rd; end
        if (chain) drive_req(na, nwe, nsz, nwd);
      end
      #1;
      chk(pri_vec == bus_vec(a, we, sz, wd, (i == 0), 1'b0), "R2/R4/R5/R10 primary outputs",
          80'(pri_vec), 80'(bus_vec(a, we, sz, wd, (i == 0), 1'b0)));
      chk(cal_vec == bus_vec(a, we, sz, wd, (i == 0), 1'b1), "R2/R3/R4/R5/R10 calibration outputs",
          80'(cal_vec), 80'(bus_vec(a, we, sz, wd, (i == 0), 1'b1)));
      if (i == 0) chk({pri_burst_o, cal_burst_o} == 2'b00, "R9 burst low",
                      80'({pri_burst_o, cal_burst_o}), 80'(0));
      if (i > 0) chk(rsp_valid_o == 1'b0, "R6 response pulse width", 80'(rsp_valid_o), 80'(0));
      if (i < waits) chk(req_ready_o == 1'b0, "R11 not ready while waiting", 80'(req_ready_o), 80'(0));
      else if (chain) chk(req_ready_o == same, "R7/R8 ready in acknowledge cycle",
                          80'(req_ready_o), 80'(same));
      @(posedge clk_i);
      @(negedge clk_i);
    end
    pri_ta_i = 1'b0;
    cal_ta_i = 1'b0;
    #1;
    chk(rsp_valid_o == 1'b1, "R6 response after acknowledge", 80'(rsp_valid_o), 80'(1));
    chk(rsp_rdata_o == (we ? 32'h0 : rd), "R6 response data", 80'(rsp_rdata_o), 80'(we ? 32'h0 : rd));
    if (!chain) begin
      chk({pri_vec, cal_vec} == '0, "R3 both buses quiet after completion", 80'(pri_vec | cal_vec), 80'(0));
      chk(req_ready_o == 1'b1, "R11 ready after completion", 80'(req_ready_o), 80'(1));
    end else if (same) begin
      req_valid_i = 1'b0;
    end else begin
      chk({pri_vec, cal_vec} == '0, "R8 dead cycle quiet", 80'(pri_vec | cal_vec), 80'(0));
      chk(req_ready_o == 1'b1, "R8 ready in dead cycle", 80'(req_ready_o), 80'(1));
      @(posedge clk_i);
      @(negedge clk_i);
      req_valid_i = 1'b0;
    end
  endtask

  task automatic pair(input logic [23:0] a1, input logic we1, input int w1,
                      input logic [23:0] a2, input logic we2, input int w2);
    logic [31:0] d1, d2;
    logic [1:0]  s1, s2;
    d1 = $urandom; d2 = $urandom; s1 = 2'($urandom); s2 = 2'($urandom);
    launch(a1, we1, s1, d1);
    serve(a1, we1, s1, d1, w1, 1'b1, a2, we2, s2, d2);
    serve(a2, we2, s2, d2, w2, 1'b0, '0, 1'b0, 2'b00, '0);
  endtask

  function automatic logic [23:0] rand_addr();
    logic [3:0] top;
    top = 4'($urandom % 6);
    return {top, 20'($urandom)};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [23:0] ca, na;
    logic        cw, nw;
    logic [1:0]  cs, ns;
    logic [31:0] cd, nd;
    bit          ch;
    void'($urandom(32'h1234abcd));

    // R1 reset state
    repeat (2) @(negedge clk_i);
    chk({pri_vec, cal_vec} == '0, "R1 bus outputs in reset", 80'(pri_vec | cal_vec), 80'(0));
    chk(rsp_valid_o == 1'b0, "R1 no response in reset", 80'(rsp_valid_o), 80'(0));
    chk(req_ready_o == 1'b1, "R1 ready in reset", 80'(req_ready_o), 80'(1));
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({pri_vec, cal_vec} == '0, "R1 bus outputs after reset", 80'(pri_vec | cal_vec), 80'(0));
    chk(req_ready_o == 1'b1, "R1 ready after reset", 80'(req_ready_o), 80'(1));

    // single accesses: R2 routing per region, R5 hold through waits
    launch(24'h012345, 1'b0, 2'b10, 32'h0);
    serve(24'h012345, 1'b0, 2'b10, 32'h0, 0, 1'b0, '0, 1'b0, 2'b00, '0);
    launch(24'h2ABCDE, 1'b1, 2'b01, 32'hCAFE0001);
    serve(24'h2ABCDE, 1'b1, 2'b01, 32'hCAFE0001, 2, 1'b0, '0, 1'b0, 2'b00, '0);
    launch(24'h3F0000, 1'b0, 2'b00, 32'h0);
    serve(24'h3F0000, 1'b0, 2'b00, 32'h0, 3, 1'b0, '0, 1'b0, 2'b00, '0);
    launch(24'h5FFFFF, 1'b0, 2'b11, 32'h0);
    serve(24'h5FFFFF, 1'b0, 2'b11, 32'h0, 1, 1'b0, '0, 1'b0, 2'b00, '0);

    // R7 same target chains, R8 target changes
    pair(24'h100010, 1'b0, 0, 24'h1FFFF0, 1'b1, 1);
    pair(24'h300004, 1'b1, 1, 24'h000008, 1'b0, 0);
    pair(24'h000000, 1'b0, 2, 24'h100000, 1'b0, 0);
    pair(24'h400000, 1'b1, 0, 24'hE00000, 1'b0, 0);
    pair(24'h200000, 1'b0, 1, 24'h2FFFFF, 1'b0, 2);
    pair(24'h100000, 1'b1, 0, 24'h200000, 1'b1, 0);
    pair(24'h200000, 1'b0, 0, 24'h300000, 1'b0, 0);

    // seeded random mix
    ca = rand_addr(); cw = 1'($urandom); cs = 2'($urandom); cd = $urandom;
    launch(ca, cw, cs, cd);
    for (int k = 0; k < 300; k++) begin
      na = rand_addr(); nw = 1'($urandom); ns = 2'($urandom); nd = $urandom;
      ch = (k != 299) && 1'($urandom % 2);
      serve(ca, cw, cs, cd, int'($urandom % 4), ch, na, nw, ns, nd);
      if (!ch && k != 299) begin
        if (1'($urandom % 2)) @(negedge clk_i);
        launch(na, nw, ns, nd);
      end
      ca = na; cw = nw; cs = ns; cd = nd;
    end

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule